// File: doc/BRIEF.md
# Lockable Memory Remap Window Decoder

This block holds the two configuration registers that define one memory remap window, a lower bound and an upper bound, and decides for every physical address presented to it whether that address falls inside the window. Software programs the bounds through a small register port that has a byte offset, 64-bit write data, byte enables and a write strobe. The address side is a 36-bit address input with a single hit output that needs no clock.

Each bound keeps a 16-bit field that gives address bits 35:20. The lower bound is filled with zeros below bit 20 and the upper bound is filled with ones, so the window always starts on a 1 MB boundary and ends one byte below one. If the lower bound is programmed above the upper bound, the window is off. Each register has a sticky lock bit that freezes all of its writable state, the lock bit included. A separate external level input freezes only the address fields of both registers.

Top module: `remap_window_dec`

## Requirements
- R1: After reset the base register reads 64'h0000_000F_FFF0_0000, the limit register reads 64'h0, and hit is low for every address.
- R2: The base register is at byte offset 8'h90 and the limit register is at 8'h98. Each register keeps its address field in bits 35:20 and its lock bit in bit 0. Bits 63:36 and 19:1 read as zero and ignore writes.
- R3: hit is high when {base_field, 20'h00000} <= addr_in <= {limit_field, 20'hFFFFF}. Both end points are inside the window.
- R4: When the base field is greater than the limit field, hit is low for all addresses. When the two fields are equal, the window is exactly 1 MB.
- R5: A write changes only the bytes whose wr_be bit is set. Byte 2 holds field bits 23:20, byte 3 holds bits 31:24, byte 4 holds bits 35:32, and byte 0 holds the lock bit.
- R6: Writing 1 to bit 0 sets that register's lock. Once the lock is set, all later writes to that register are ignored, a write that clears the lock included, until reset. The other register stays writable.
- R7: While ext_lock is high, writes to the address fields of both registers are ignored. A lock bit that is still clear can still be set.
- R8: A write changes hit and rd_data from the cycle after the write, not before. A single write that carries both a new field and lock=1 applies both.
- R9: Writes to any offset other than 8'h90 and 8'h98 change nothing. Reads from any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_off | input | 8 | Write byte offset |
| wr_be | input | 8 | Write byte enables |
| wr_data | input | 64 | Write data |
| rd_off | input | 8 | Read byte offset |
| rd_data | output | 64 | Read data, combinational |
| ext_lock | input | 1 | External freeze of the address fields (level) |
| addr_in | input | 36 | Physical address to classify |
| hit | output | 1 | Address lies inside the enabled window |

## Verification
Two pairs of functions can fall in the same cycle. The first is a field update and a lock set carried by one write. The bench issues such writes to one register, with ext_lock low and with it high, and judges the result by reading back both the field and the lock bit afterwards. The second is an address lookup and a write that moves a bound. The bench holds an address steady while a write that disables the window is on the port, and checks that hit keeps its old value before the edge and changes only after it.

// File: rtl/remap_window_dec.sv
module remap_window_dec #(
  parameter int ADDR_W = 36,
  parameter int FLD_LO = 20,
  parameter int DATA_W = 64,
  parameter int OFF_W  = 8,
  parameter logic [OFF_W-1:0] BASE_OFF  = 'h90,
  parameter logic [OFF_W-1:0] LIMIT_OFF = 'h98
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W/8-1:0] wr_be,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ext_lock,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              hit
);
  localparam int FLD_W = ADDR_W - FLD_LO;
  localparam logic [FLD_W-1:0] BASE_RST  = '1;
  localparam logic [FLD_W-1:0] LIMIT_RST = '0;

  logic [FLD_W-1:0] base_fld, limit_fld, fmask, fdata, base_nxt, limit_nxt;
  logic             base_lock, limit_lock;
  logic             sel_base, sel_limit, set_lock;
  logic [DATA_W-1:0] base_word, limit_word;
  logic             unused_in;

  for (genvar i = 0; i < FLD_W; i++) begin : g_fmask
    assign fmask[i] = wr_be[(i + FLD_LO) / 8];
  end

  assign fdata     = wr_data[ADDR_W-1:FLD_LO];
  assign sel_base  = wr_en && (wr_off == BASE_OFF);
  assign sel_limit = wr_en && (wr_off == LIMIT_OFF);
  assign set_lock  = wr_be[0] && wr_data[0];
  assign base_nxt  = (fdata & fmask) | (base_fld & ~fmask);
  assign limit_nxt = (fdata & fmask) | (limit_fld & ~fmask);
  assign unused_in = ^{wr_data, wr_be};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_fld   <= BASE_RST;
      limit_fld  <= LIMIT_RST;
      base_lock  <= 1'b0;
      limit_lock <= 1'b0;
    end else begin
      if (sel_base && !base_lock) begin
        if (!ext_lock) base_fld <= base_nxt;
        if (set_lock)  base_lock <= 1'b1;
      end
      if (sel_limit && !limit_lock) begin
        if (!ext_lock) limit_fld <= limit_nxt;
        if (set_lock)  limit_lock <= 1'b1;
      end
    end
  end

  assign base_word  = ({{(DATA_W-FLD_W){1'b0}}, base_fld} << FLD_LO)
                    | {{(DATA_W-1){1'b0}}, base_lock};
  assign limit_word = ({{(DATA_W-FLD_W){1'b0}}, limit_fld} << FLD_LO)
                    | {{(DATA_W-1){1'b0}}, limit_lock};

  always_comb begin
    rd_data = '0;
    if (rd_off == BASE_OFF)       rd_data = base_word;
    else if (rd_off == LIMIT_OFF) rd_data = limit_word;
  end

  // The low-bit fills make a comparison on bits above FLD_LO exact.
  logic [FLD_W-1:0] addr_hi;
  logic             win_on;
  assign addr_hi = addr_in[ADDR_W-1:FLD_LO];
  assign win_on  = base_fld <= limit_fld;
  assign hit     = win_on && (addr_hi >= base_fld) && (addr_hi <= limit_fld);

  // R6
  base_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_lock |=> ($stable(base_fld) && base_lock));
  // R6
  limit_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    limit_lock |=> ($stable(limit_fld) && limit_lock));
  // R7
  ext_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_lock |=> ($stable(base_fld) && $stable(limit_fld)));
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[DATA_W-1:ADDR_W] == '0) && (rd_data[FLD_LO-1:1] == '0));
  // R4
  hit_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (rd_off != BASE_OFF || rd_data[ADDR_W-1:FLD_LO] <= addr_hi));
endmodule

// File: tb/remap_window_dec_tb_top.sv
module remap_window_dec_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [7:0]  wr_off = 0;
  logic [7:0]  wr_be = 0;
  logic [63:0] wr_data = 0;
  logic [7:0]  rd_off = 0;
  logic [63:0] rd_data;
  logic        ext_lock = 0;
  logic [35:0] addr_in = 0;
  logic        hit;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  remap_window_dec dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_be(wr_be),
    .wr_data(wr_data), .rd_off(rd_off), .rd_data(rd_data), .ext_lock(ext_lock),
    .addr_in(addr_in), .hit(hit));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; wr_en = 0; ext_lock = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(logic [7:0] off, logic [63:0] d, logic [7:0] be);
    @(negedge clk); wr_en = 1; wr_off = off; wr_data = d; wr_be = be;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] off, logic [63:0] exp);
    rd_off = off; #1; chk(tag, rd_data, exp);
  endtask

  task automatic hit_chk(string tag, logic [35:0] a, logic exp);
    addr_in = a; #1; chk(tag, {63'b0, hit}, {63'b0, exp});
  endtask

  task automatic t_reset();
    do_reset();
    rd_chk("R1 base reset", 8'h90, 64'h0000_000F_FFF0_0000);
    rd_chk("R1 limit reset", 8'h98, 64'h0);
    hit_chk("R1 hit addr 0", 36'h0, 0);
    hit_chk("R1 hit addr max", 36'hF_FFFF_FFFF, 0);
  endtask

  task automatic t_window();
    do_reset();
    wr(8'h90, 64'h0100_0000, 8'hFF);
    wr(8'h98, 64'h0200_0000, 8'hFF);
    rd_chk("R2 base readback", 8'h90, 64'h0100_0000);
    rd_chk("R2 limit readback", 8'h98, 64'h0200_0000);
    hit_chk("R3 base edge", 36'h0_0100_0000, 1);
    hit_chk("R3 below base", 36'h0_00FF_FFFF, 0);
    hit_chk("R3 limit edge", 36'h0_020F_FFFF, 1);
    hit_chk("R3 above limit", 36'h0_0210_0000, 0);
  endtask

  task automatic t_reserved_disable();
    do_reset();
    wr(8'h98, 64'h0200_0000, 8'hFF);
    wr(8'h90, 64'hFFFF_FFF0_030F_FFFE, 8'hFF);
    rd_chk("R2 reserved ignored", 8'h90, 64'h0300_0000);
    hit_chk("R4 disabled at base", 36'h0_0300_0000, 0);
    hit_chk("R4 disabled mid", 36'h0_0200_0000, 0);
    wr(8'h98, 64'h0300_0000, 8'hFF);
    hit_chk("R4 equal low", 36'h0_0300_0000, 1);
    hit_chk("R4 equal high", 36'h0_030F_FFFF, 1);
    hit_chk("R4 equal above", 36'h0_0310_0000, 0);
  endtask

  task automatic t_byte_en();
    do_reset();
    wr(8'h90, 64'h0300_0000, 8'hFF);
    wr(8'h90, 64'h0000_000F_FFF0_0001, 8'h08);
    rd_chk("R5 byte3 only", 8'h90, 64'hFF00_0000);
    wr(8'h90, 64'h0000_000F_FFF0_0001, 8'h00);
    rd_chk("R5 no enables", 8'h90, 64'hFF00_0000);
    wr(8'h90, 64'h0000_0005_0000_0000, 8'h10);
    rd_chk("R5 byte4 only", 8'h90, 64'h0000_0005_FF00_0000);
  endtask

  task automatic t_lock();
    do_reset();
    wr(8'h90, 64'h0100_0001, 8'hFF);
    rd_chk("R8 field+lock same write", 8'h90, 64'h0100_0001);
    wr(8'h90, 64'h0, 8'hFF);
    rd_chk("R6 locked ignores write", 8'h90, 64'h0100_0001);
    wr(8'h98, 64'h0200_0000, 8'hFF);
    rd_chk("R6 other register free", 8'h98, 64'h0200_0000);
    hit_chk("R6 window live", 36'h0_0180_0000, 1);
  endtask

  task automatic t_ext_lock();
    do_reset();
    @(negedge clk); ext_lock = 1;
    wr(8'h90, 64'h0100_0000, 8'hFF);
    rd_chk("R7 base field frozen", 8'h90, 64'h0000_000F_FFF0_0000);
    wr(8'h98, 64'h0200_0001, 8'hFF);
    rd_chk("R7 lock still settable", 8'h98, 64'h1);
    @(negedge clk); ext_lock = 0;
    wr(8'h98, 64'h0200_0000, 8'hFF);
    rd_chk("R6 lock survives ext release", 8'h98, 64'h1);
    wr(8'h90, 64'h0100_0000, 8'hFF);
    rd_chk("R7 base writable after release", 8'h90, 64'h0100_0000);
  endtask

  task automatic t_timing();
    do_reset();
    wr(8'h90, 64'h0100_0000, 8'hFF);
    wr(8'h98, 64'h0100_0000, 8'hFF);
    addr_in = 36'h0_0100_0000;
    @(negedge clk); wr_en = 1; wr_off = 8'h90; wr_data = 64'h0110_0000; wr_be = 8'hFF;
    #1; chk("R8 hit before edge", {63'b0, hit}, 64'h1);
    @(negedge clk); wr_en = 0;
    #1; chk("R8 hit after edge", {63'b0, hit}, 64'h0);
  endtask

  task automatic t_other_off();
    do_reset();
    wr(8'hA0, 64'h0100_0001, 8'hFF);
    wr(8'h94, 64'h0100_0001, 8'hFF);
    wr(8'h88, 64'h0100_0001, 8'hFF);
    rd_chk("R9 base untouched", 8'h90, 64'h0000_000F_FFF0_0000);
    rd_chk("R9 limit untouched", 8'h98, 64'h0);
    rd_chk("R9 other read zero", 8'hA0, 64'h0);
  endtask

  initial begin
    t_reset();
    t_window();
    t_reserved_disable();
    t_byte_en();
    t_lock();
    t_ext_lock();
    t_timing();
    t_other_off();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule